// File: doc/BRIEF.md
# Window Pattern Histogram Accumulator

This block learns how often each local texture occurs in a stream of quantised images. Pixels arrive one per valid cycle in raster order. Two line buffers and a three-column shift register build the 3x3 neighbourhood that ends at each incoming pixel. The nine pixel codes are joined into one pattern code, and that code is used as the address of a counter memory. Each complete neighbourhood reads its counter, adds one and writes the result back.

`PIX_W` sets the pixel depth: 1 bit for black and white, 2 bits for four grey levels. The memory therefore holds 2^(9*PIX_W) counters, each `CNT_W` bits wide. Software, or a training sequencer, first issues a clear, which sweeps the whole memory to zero. It then streams frames with accumulation enabled. Afterwards it disables accumulation and starts a dump, which returns every counter in address order over a valid/ready handshake.

Top module: `whp_top`

## Requirements
- R1: The pattern code is 9*PIX_W bits wide and is the counter address. It joins the window pixels row by row, starting with the oldest row, and left to right within a row. The top-left pixel occupies the most significant PIX_W bits and the newest pixel occupies the least significant PIX_W bits.
- R2: With accumulation enabled, each complete window adds exactly one to the counter at its pattern code.
- R3: A pixel in frame row 0 or 1, or in column 0 or 1, completes no window and changes no counter.
- R4: A counter that holds 2^CNT_W-1 keeps that value when it is hit again.
- R5: Hits on the same pattern in consecutive cycles, or at any other spacing, each add one. No increment is lost.
- R6: A pixel that carries frame_start is row 0, column 0. A pixel that carries frame_end is the last pixel of the frame. Valid pixels after frame_end and before the next frame_start are ignored.
- R7: While acc_en is low, incoming pixels change no counter.
- R8: A clear_req while idle raises busy on the next cycle. Busy stays high for exactly 2^(9*PIX_W) cycles, after which every counter reads zero.
- R9: A dump_start while acc_en is low and the block is idle returns counters at addresses 0 up to 2^(9*PIX_W)-1, in ascending order. Each entry keeps dump_valid, dump_addr and dump_count steady until it is taken with dump_ready. A dump_start while acc_en is high is ignored.
- R10: After reset, busy and dump_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Enables counting of windows |
| pix_valid | input | 1 | Pixel present this cycle |
| frame_start | input | 1 | Marks the first pixel of a frame |
| frame_end | input | 1 | Marks the last pixel of a frame |
| pix_code | input | PIX_W | Quantised pixel value |
| clear_req | input | 1 | Starts the zeroing sweep |
| busy | output | 1 | High during the zeroing sweep |
| dump_start | input | 1 | Starts the readout of all counters |
| dump_ready | input | 1 | Consumer takes the current entry |
| dump_valid | output | 1 | Readout entry present |
| dump_addr | output | 9*PIX_W | Pattern code of the readout entry |
| dump_count | output | CNT_W | Counter value of the readout entry |

## Verification
A counter write lands two clock edges after the pixel that completes its window. The bench therefore leaves at least four idle cycles after each frame before it starts a dump, and judges all counting results only through the readout. Busy must be seen high at the first falling edge after the clear request, and the bench counts the high cycles until it falls. Each readout entry becomes valid two cycles after the previous one was taken. The bench checks an entry the first time it sees dump_valid on a falling edge, and it advances its own expected address only when it has driven dump_ready high for that entry.

// File: rtl/whp_pkg.sv
package whp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_DUMP_RD,
        ST_DUMP_HOLD
    } whp_state_e;
endpackage

// File: rtl/whp_window.sv
module whp_window #(
    parameter int PIX_W = 1,
    parameter int IMG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               pix_valid,
    input  logic               frame_start,
    input  logic               frame_end,
    input  logic [PIX_W-1:0]   pix_code,
    output logic               upd_valid,
    output logic [9*PIX_W-1:0] upd_addr
);
    localparam int COL_W = $clog2(IMG_W);
    localparam int CW    = 3 * PIX_W;

    typedef struct packed {
        logic               in_frame;
        logic [COL_W-1:0]   col;
        logic [1:0]         row;   // saturates at 2: only "row >= 2" matters
        logic [CW-1:0]      c1;    // column c-2, {top, mid, bottom}
        logic [CW-1:0]      c0;    // column c-1
        logic               upd_v;
        logic [9*PIX_W-1:0] upd_a;
    } win_s;

    win_s win_d, win_q;

    logic [PIX_W-1:0] lb0 [IMG_W];  // previous row
    logic [PIX_W-1:0] lb1 [IMG_W];  // row before that

    logic             take;
    logic [COL_W-1:0] cur_col;
    logic [1:0]       cur_row;
    logic [CW-1:0]    newcol;

    always_comb begin
        win_d   = win_q;
        take    = pix_valid && (frame_start || win_q.in_frame);
        cur_col = frame_start ? '0 : win_q.col;
        cur_row = frame_start ? 2'd0 : win_q.row;
        newcol  = {lb1[cur_col], lb0[cur_col], pix_code};

        win_d.upd_v = take && acc_en && (cur_row == 2'd2) && (cur_col >= COL_W'(2));
        win_d.upd_a = {win_q.c1[CW-1:2*PIX_W], win_q.c0[CW-1:2*PIX_W], newcol[CW-1:2*PIX_W],
                       win_q.c1[2*PIX_W-1:PIX_W], win_q.c0[2*PIX_W-1:PIX_W], newcol[2*PIX_W-1:PIX_W],
                       win_q.c1[PIX_W-1:0], win_q.c0[PIX_W-1:0], newcol[PIX_W-1:0]};

        if (take) begin
            win_d.c1       = win_q.c0;
            win_d.c0       = newcol;
            win_d.in_frame = !frame_end;
            if (cur_col == COL_W'(IMG_W - 1)) begin
                win_d.col = '0;
                win_d.row = (cur_row == 2'd2) ? 2'd2 : cur_row + 2'd1;
            end else begin
                win_d.col = cur_col + COL_W'(1);
                win_d.row = cur_row;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    always_ff @(posedge clk) begin
        if (take) begin
            lb1[cur_col] <= lb0[cur_col];
            lb0[cur_col] <= pix_code;
        end
    end

    assign upd_valid = win_q.upd_v;
    assign upd_addr  = win_q.upd_a;
endmodule

// File: rtl/whp_count_mem.sv
module whp_count_mem
    import whp_pkg::*;
#(
    parameter int AW    = 9,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             upd_valid,
    input  logic [AW-1:0]    upd_addr,
    input  logic             clear_req,
    input  logic             dump_start,
    input  logic             dump_ready,
    output logic             busy,
    output logic             dump_valid,
    output logic [AW-1:0]    dump_addr,
    output logic [CNT_W-1:0] dump_count
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        whp_state_e       state;
        logic [AW-1:0]    ptr;
        logic             b_v;    // increment stage valid
        logic [AW-1:0]    b_a;
        logic             wl_v;   // last write, kept for forwarding
        logic [AW-1:0]    wl_a;
        logic [CNT_W-1:0] wl_d;
    } mem_s;

    mem_s m_d, m_q;

    logic [CNT_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] rdata_q;
    logic [AW-1:0]    rd_addr;
    logic [CNT_W-1:0] base, inc;
    logic             we;
    logic [AW-1:0]    wa;
    logic [CNT_W-1:0] wd;
    logic             last_ptr;

    always_comb begin
        m_d      = m_q;
        last_ptr = (m_q.ptr == AW'(DEPTH - 1));
        rd_addr  = (m_q.state == ST_DUMP_RD || m_q.state == ST_DUMP_HOLD) ? m_q.ptr : upd_addr;

        base = (m_q.wl_v && m_q.wl_a == m_q.b_a) ? m_q.wl_d : rdata_q;
        inc  = (&base) ? base : base + CNT_W'(1);

        we = 1'b0;
        wa = m_q.b_a;
        wd = inc;
        if (m_q.state == ST_CLEAR) begin
            we = 1'b1;
            wa = m_q.ptr;
            wd = '0;
        end else if (m_q.b_v) begin
            we = 1'b1;
        end
        m_d.wl_v = we;
        m_d.wl_a = wa;
        m_d.wl_d = wd;

        m_d.b_v = upd_valid && (m_q.state == ST_IDLE);
        m_d.b_a = upd_addr;

        unique case (m_q.state)
            ST_IDLE: begin
                if (clear_req) begin
                    m_d.state = ST_CLEAR;
                    m_d.ptr   = '0;
                end else if (dump_start && !acc_en) begin
                    m_d.state = ST_DUMP_RD;
                    m_d.ptr   = '0;
                end
            end
            ST_CLEAR: begin
                m_d.ptr = m_q.ptr + AW'(1);
                if (last_ptr) m_d.state = ST_IDLE;
            end
            ST_DUMP_RD: m_d.state = ST_DUMP_HOLD;
            ST_DUMP_HOLD: begin
                if (dump_ready) begin
                    if (last_ptr) begin
                        m_d.state = ST_IDLE;
                    end else begin
                        m_d.ptr   = m_q.ptr + AW'(1);
                        m_d.state = ST_DUMP_RD;
                    end
                end
            end
            default: m_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    always_ff @(posedge clk) begin
        rdata_q <= mem[rd_addr];
        if (we) mem[wa] <= wd;
    end

    assign busy       = (m_q.state == ST_CLEAR);
    assign dump_valid = (m_q.state == ST_DUMP_HOLD);
    assign dump_addr  = m_q.ptr;
    assign dump_count = rdata_q;
endmodule

// File: rtl/whp_top.sv
module whp_top #(
    parameter int PIX_W = 1,
    parameter int IMG_W = 16,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               pix_valid,
    input  logic               frame_start,
    input  logic               frame_end,
    input  logic [PIX_W-1:0]   pix_code,
    input  logic               clear_req,
    output logic               busy,
    input  logic               dump_start,
    input  logic               dump_ready,
    output logic               dump_valid,
    output logic [9*PIX_W-1:0] dump_addr,
    output logic [CNT_W-1:0]   dump_count
);
    localparam int AW = 9 * PIX_W;

    logic          upd_valid;
    logic [AW-1:0] upd_addr;

    whp_window #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_win (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .pix_valid(pix_valid),
        .frame_start(frame_start), .frame_end(frame_end), .pix_code(pix_code),
        .upd_valid(upd_valid), .upd_addr(upd_addr)
    );

    whp_count_mem #(.AW(AW), .CNT_W(CNT_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .upd_valid(upd_valid),
        .upd_addr(upd_addr), .clear_req(clear_req), .dump_start(dump_start),
        .dump_ready(dump_ready), .busy(busy), .dump_valid(dump_valid),
        .dump_addr(dump_addr), .dump_count(dump_count)
    );
endmodule

// File: rtl/whp_checker.sv
module whp_checker #(
    parameter int AW    = 9,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             dump_valid,
    input logic             dump_ready,
    input logic [AW-1:0]    dump_addr,
    input logic [CNT_W-1:0] dump_count
);
    localparam int DEPTH = 1 << AW;

    logic [AW:0] busy_run;
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + (AW+1)'(1);
        else           busy_run <= '0;
    end

    AST_BUSY_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < (AW+1)'(DEPTH))); // R8

    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_run == (AW+1)'(DEPTH - 1)) |=> !busy); // R8

    AST_NO_DUMP_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dump_valid); // R9

    AST_DUMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_valid && !dump_ready) |=> (dump_valid && $stable(dump_addr) && $stable(dump_count))); // R9

    AST_DUMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_valid && dump_ready && dump_addr != AW'(DEPTH - 1))
            |=> !dump_valid ##1 (dump_valid && dump_addr == $past(dump_addr, 2) + AW'(1))); // R9
endmodule

bind whp_top whp_checker #(.AW(9 * PIX_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dump_valid(dump_valid),
    .dump_ready(dump_ready), .dump_addr(dump_addr), .dump_count(dump_count)
);

// File: tb/sim_whp_top.sv
`timescale 1ns/1ps
module sim_whp_top;
    localparam int PIX_W = 1;
    localparam int IMG_W = 8;
    localparam int CNT_W = 4;
    localparam int AW    = 9 * PIX_W;
    localparam int DEPTH = 1 << AW;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_en = 1'b0, pix_valid = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
    logic [PIX_W-1:0] pix_code = '0;
    logic clear_req = 1'b0, dump_start = 1'b0, dump_ready = 1'b0;
    logic busy, dump_valid;
    logic [AW-1:0] dump_addr;
    logic [CNT_W-1:0] dump_count;

    always #4 clk = ~clk;

    whp_top #(.PIX_W(PIX_W), .IMG_W(IMG_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .pix_valid(pix_valid),
        .frame_start(frame_start), .frame_end(frame_end), .pix_code(pix_code),
        .clear_req(clear_req), .busy(busy), .dump_start(dump_start),
        .dump_ready(dump_ready), .dump_valid(dump_valid), .dump_addr(dump_addr),
        .dump_count(dump_count)
    );

    int vectors = 0;
    int miscompares = 0;
    int expc [DEPTH];
    int img [8][IMG_W];
    bit done = 1'b0;

    task automatic chk(string req, int act, int expv);
        vectors++;
        if (act != expv) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int win_code(int r, int c);
        int code = 0;
        for (int dr = 0; dr < 3; dr++)
            for (int dc = 0; dc < 3; dc++)
                code = (code << PIX_W) | img[r - 2 + dr][c - 2 + dc];
        return code;
    endfunction

    function automatic void model_frame(int h);
        for (int r = 2; r < h; r++)
            for (int c = 2; c < IMG_W; c++) begin
                int k = win_code(r, c);
                if (expc[k] < CMAX) expc[k]++;
            end
    endfunction

    // mode 0 random, 1 all zero; gaps inserts idle cycles between pixels
    task automatic send_frame(int h, int mode, bit en, bit gaps);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < IMG_W; c++)
                img[r][c] = (mode == 0) ? int'($urandom % (1 << PIX_W)) : 0;
        acc_en = en;
        for (int r = 0; r < h; r++)
            for (int c = 0; c < IMG_W; c++) begin
                if (gaps && ($urandom % 4 == 0)) begin
                    pix_valid = 1'b0;
                    repeat (1 + $urandom % 2) @(negedge clk);
                end
                pix_valid   = 1'b1;
                pix_code    = PIX_W'(img[r][c]);
                frame_start = (r == 0 && c == 0);
                frame_end   = (r == h - 1 && c == IMG_W - 1);
                @(negedge clk);
            end
        frame_start = 1'b0;
        frame_end   = 1'b0;
        // R6: stray pixels after frame end, must be ignored
        for (int i = 0; i < 2 * IMG_W; i++) begin
            pix_valid = 1'b1;
            pix_code  = PIX_W'($urandom);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        if (en) model_frame(h);
        repeat (4) @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic do_clear();
        int n = 0;
        clear_req = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        chk("R8 busy raised", int'(busy), 1);
        while (busy && n < 2 * DEPTH) begin
            n++;
            @(negedge clk);
        end
        chk("R8 busy length", n, DEPTH);
        for (int i = 0; i < DEPTH; i++) expc[i] = 0;
    endtask

    task automatic do_dump(string tag);
        int idx = 0;
        int guard = 0;
        bit seen = 1'b0;
        acc_en = 1'b0;
        dump_start = 1'b1;
        @(negedge clk);
        dump_start = 1'b0;
        while (idx < DEPTH && guard < 8 * DEPTH) begin
            bit rdy;
            guard++;
            if (dump_valid && !seen) begin
                chk({"R9 addr ", tag}, int'(dump_addr), idx);
                chk({"R2 count ", tag}, int'(dump_count), expc[idx]);
                seen = 1'b1;
            end
            rdy = ($urandom % 2 == 0);
            dump_ready = rdy;
            if (dump_valid && rdy) begin
                idx++;
                seen = 1'b0;
            end
            @(negedge clk);
        end
        dump_ready = 1'b0;
        chk({"R9 entries ", tag}, idx, DEPTH);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 busy", int'(busy), 0);
        chk("R10 dump_valid", int'(dump_valid), 0);

        do_clear();
        do_dump("after clear R8");

        // R5: three-row zero frame gives 6 back-to-back hits on pattern 0
        send_frame(3, 1, 1'b1, 1'b0);
        do_dump("R5 back-to-back");

        // R4: eight-row zero frame drives pattern 0 into saturation
        send_frame(8, 1, 1'b1, 1'b0);
        do_dump("R4 saturate");

        // R1 R2 R3 R6: random frames, with and without gaps
        do_clear();
        for (int f = 0; f < 5; f++) send_frame(8, 0, 1'b1, f[0]);
        send_frame(5, 0, 1'b1, 1'b1);
        do_dump("R1 R3 random");

        // R7: disabled accumulation leaves counts untouched
        send_frame(8, 0, 1'b0, 1'b1);
        do_dump("R7 disabled");

        // R9: dump_start ignored while accumulating
        acc_en = 1'b1;
        dump_start = 1'b1;
        @(negedge clk);
        dump_start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk("R9 dump ignored", int'(dump_valid), 0);
            @(negedge clk);
        end
        acc_en = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule